// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block keeps the receive and transmit interrupt state of two serial channels, called A (index 0) and B (index 1), and turns it into one shared interrupt line, a pending-bits register and a modified vector register that software reads to find the cause. Its inputs are single-cycle event strobes from each channel's datapath: a byte received, a byte written to the transmit buffer, a byte read from the receive buffer. It also takes command strobes from each channel's command register, and the enable settings held in the write registers.

Receive has priority over transmit. While a receive interrupt is in service, a transmit event is only remembered. Its vector and pending bit are posted when the receive service ends, whether that is through a data read or through the reset-highest-in-service command. A single status-high control bit chooses between two vector layouts: one where the code sits in bits 6:4 and one where it sits in bits 3:1.

Top module: `irq_vector_ctl`

## Requirements
- R1: The irq output goes high when a channel has any of three conditions: (a) transmit enable and transmit pending, (b) receive mode 2'b01 or 2'b10 and receive pending, or (c) break enable and break status. It is registered, so it follows a state change one clock later than pend_reg and vec_reg.
- R2: A receive mode of 2'b00 or 2'b11 never raises irq from receive pending.
- R3: A received byte sets that channel's receive pending and receive in-service state. It sets pend_reg bit 5 for A or bit 2 for B, and it loads the receive vector.
- R4: With status_hi set, vec_reg is 0x60 for none, 0x30 for receive A, 0x20 for receive B and 0x10 for transmit A. With status_hi clear, these are 0x06, 0x0C, 0x04 and 0x08. Transmit B is 0x00 in both layouts.
- R5: A transmit-buffer write latches transmit pending. If no receive is in service on that channel, it also loads the transmit vector and, when transmit enable is set, sets pend_reg bit 4 for A or bit 1 for B. Otherwise nothing is posted.
- R6: A data read clears receive pending, in-service and the receive pend_reg bit, and sets the vector to none. It then posts any latched transmit pending as in R5.
- R7: Command code 3'b101 clears transmit pending and the transmit pend_reg bit and sets the vector to none. It then re-posts any latched receive pending as in R3.
- R8: Command code 3'b111 clears receive in-service if it is set and then posts any latched transmit pending. With no receive in service, it changes no output. Every other command code has no effect.
- R9: pend_reg bit 3 (A) and bit 0 (B) show break enable AND break status, registered in step with irq. Bits 7:6 read zero.
- R10: After reset, all pending and in-service state is clear, pend_reg and vec_reg are 0x00, and irq is low.
- R11: Events that arrive in the same cycle are applied in a fixed order. Channel A is handled before channel B. Within a channel the order is receive byte, data read, command, then transmit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_hi | input | 1 | Selects the high-bit vector layout |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 2x2 | Receive interrupt mode per channel |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status per channel |
| rx_byte | input | 2 | Byte-received strobe per channel |
| tx_wr | input | 2 | Transmit-buffer write strobe per channel |
| rd_data | input | 2 | Receive data read strobe per channel |
| cmd_strobe | input | 2 | Command written strobe per channel |
| cmd_code | input | 2x3 | Command field per channel |
| irq | output | 1 | Shared interrupt request |
| pend_reg | output | 8 | Interrupt pending bits |
| vec_reg | output | 8 | Modified interrupt vector |

## Verification
The hardest situation to reach is a transmit interrupt that is held off by a receive in service and then released. The stimulus sets this up by receiving a byte, writing the transmit buffer while the receive is still in service, and then ending the service, once by the reset-highest command and once by a data read. The vector and the pending bits are checked at each step. Events that land on both channels in one cycle exercise the fixed processing order. A one-cycle probe separates the registered irq from the immediate register update.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int NCH   = 2;
    localparam int CH_W  = $clog2(NCH);
    localparam int VEC_W = 8;
    localparam int CMD_W = 3;
    localparam int MOD_W = 2;

    typedef logic [CH_W-1:0] ch_t;
    localparam ch_t CH_A = ch_t'(0);
    localparam ch_t CH_B = ch_t'(1);

    localparam logic [CMD_W-1:0] CMD_CLR_TX  = 3'b101;
    localparam logic [CMD_W-1:0] CMD_END_SVC = 3'b111;

    typedef struct packed {
        logic [NCH-1:0]   rx_pend;
        logic [NCH-1:0]   tx_pend;
        logic [NCH-1:0]   rx_svc;
        logic [NCH-1:0]   rx_post;
        logic [NCH-1:0]   tx_post;
        logic [VEC_W-1:0] vec;
    } ivc_state_t;

    typedef struct packed {
        logic           irq;
        logic [NCH-1:0] ext;
    } ivc_out_t;

    function automatic logic [VEC_W-1:0] code_none(logic hi);
        return hi ? 8'h60 : 8'h06;
    endfunction

    function automatic logic [VEC_W-1:0] code_rx(ch_t ch, logic hi);
        if (ch == CH_A) return hi ? 8'h30 : 8'h0C;
        return hi ? 8'h20 : 8'h04;
    endfunction

    function automatic logic [VEC_W-1:0] code_tx(ch_t ch, logic hi);
        if (ch == CH_A) return hi ? 8'h10 : 8'h08;
        return 8'h00;
    endfunction

    function automatic ivc_state_t post_rx(ivc_state_t s, ch_t ch, logic hi);
        ivc_state_t r = s;
        r.rx_pend[ch] = 1'b1;
        r.rx_svc[ch]  = 1'b1;
        r.rx_post[ch] = 1'b1;
        r.vec         = code_rx(ch, hi);
        return r;
    endfunction

    function automatic ivc_state_t post_tx(ivc_state_t s, ch_t ch, logic hi, logic tie);
        ivc_state_t r = s;
        r.tx_pend[ch] = 1'b1;
        if (!r.rx_svc[ch]) begin
            if (tie) r.tx_post[ch] = 1'b1;
            r.vec = code_tx(ch, hi);
        end
        return r;
    endfunction

    function automatic ivc_state_t drop_rx(ivc_state_t s, ch_t ch, logic hi, logic tie);
        ivc_state_t r = s;
        r.rx_pend[ch] = 1'b0;
        r.rx_svc[ch]  = 1'b0;
        r.rx_post[ch] = 1'b0;
        r.vec         = code_none(hi);
        if (r.tx_pend[ch]) r = post_tx(r, ch, hi, tie);
        return r;
    endfunction

    function automatic ivc_state_t drop_tx(ivc_state_t s, ch_t ch, logic hi);
        ivc_state_t r = s;
        r.tx_pend[ch] = 1'b0;
        r.tx_post[ch] = 1'b0;
        r.vec         = code_none(hi);
        if (r.rx_pend[ch]) r = post_rx(r, ch, hi);
        return r;
    endfunction

    function automatic ivc_state_t end_service(ivc_state_t s, ch_t ch, logic hi, logic tie);
        ivc_state_t r = s;
        if (r.rx_svc[ch]) begin
            r.rx_svc[ch] = 1'b0;
            if (r.tx_pend[ch]) r = post_tx(r, ch, hi, tie);
        end
        return r;
    endfunction
endpackage

// File: rtl/ivc_req.sv
module ivc_req
    import ivc_pkg::*;
(
    input  logic             tx_ie,
    input  logic [MOD_W-1:0] rx_mode,
    input  logic             brk_ie,
    input  logic             brk_stat,
    input  logic             tx_pend,
    input  logic             rx_pend,
    output logic             req,
    output logic             brk_hit
);
    logic rx_on;

    always_comb begin
        rx_on   = (rx_mode == 2'b01) || (rx_mode == 2'b10);
        brk_hit = brk_ie & brk_stat;
        req     = (tx_ie & tx_pend) | (rx_on & rx_pend) | brk_hit;
    end
endmodule

// File: rtl/ivc_out_reg.sv
module ivc_out_reg
    import ivc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] brk_hit,
    output logic           irq,
    output logic [NCH-1:0] ext
);
    ivc_out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.irq = |req;
        out_d.ext = brk_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq = out_q.irq;
    assign ext = out_q.ext;
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
    import ivc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       status_hi,
    input  logic [NCH-1:0]             tx_ie,
    input  logic [NCH-1:0][MOD_W-1:0]  rx_mode,
    input  logic [NCH-1:0]             brk_ie,
    input  logic [NCH-1:0]             brk_stat,
    input  logic [NCH-1:0]             rx_byte,
    input  logic [NCH-1:0]             tx_wr,
    input  logic [NCH-1:0]             rd_data,
    input  logic [NCH-1:0]             cmd_strobe,
    input  logic [NCH-1:0][CMD_W-1:0]  cmd_code,
    output logic                       irq,
    output logic [VEC_W-1:0]           pend_reg,
    output logic [VEC_W-1:0]           vec_reg
);
    ivc_state_t     state_d, state_q;
    logic [NCH-1:0] req, brk_hit, ext;

    // Events applied channel A first, then B; within a channel rx, read, cmd, tx (R11).
    always_comb begin
        state_d = state_q;
        for (int c = 0; c < NCH; c++) begin
            if (rx_byte[c])
                state_d = post_rx(state_d, ch_t'(c), status_hi);
            if (rd_data[c])
                state_d = drop_rx(state_d, ch_t'(c), status_hi, tx_ie[c]);
            if (cmd_strobe[c]) begin
                if (cmd_code[c] == CMD_CLR_TX)
                    state_d = drop_tx(state_d, ch_t'(c), status_hi);
                else if (cmd_code[c] == CMD_END_SVC)
                    state_d = end_service(state_d, ch_t'(c), status_hi, tx_ie[c]);
            end
            if (tx_wr[c])
                state_d = post_tx(state_d, ch_t'(c), status_hi, tx_ie[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_req
        ivc_req u_req (
            .tx_ie    (tx_ie[g]),
            .rx_mode  (rx_mode[g]),
            .brk_ie   (brk_ie[g]),
            .brk_stat (brk_stat[g]),
            .tx_pend  (state_q.tx_pend[g]),
            .rx_pend  (state_q.rx_pend[g]),
            .req      (req[g]),
            .brk_hit  (brk_hit[g])
        );
    end

    ivc_out_reg u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .brk_hit (brk_hit),
        .irq     (irq),
        .ext     (ext)
    );

    assign pend_reg = {2'b00,
                       state_q.rx_post[CH_A], state_q.tx_post[CH_A], ext[CH_A],
                       state_q.rx_post[CH_B], state_q.tx_post[CH_B], ext[CH_B]};
    assign vec_reg  = state_q.vec;
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk
    import ivc_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            tx_ie,
    input logic [NCH-1:0][MOD_W-1:0] rx_mode,
    input logic [NCH-1:0]            brk_ie,
    input logic [NCH-1:0]            brk_stat,
    input logic [NCH-1:0]            rx_byte,
    input logic [NCH-1:0]            tx_wr,
    input logic [NCH-1:0]            rd_data,
    input logic [NCH-1:0]            cmd_strobe,
    input logic [NCH-1:0][CMD_W-1:0] cmd_code,
    input logic                      irq,
    input logic [VEC_W-1:0]          pend_reg,
    input logic [VEC_W-1:0]          vec_reg
);
    p_rx_post_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte[0] && !rd_data[0] |=> pend_reg[5]);

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] && !rx_byte[0] |=> !pend_reg[5]);

    p_clr_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe[1] && cmd_code[1] == 3'b101 && !tx_wr[1] |=> !pend_reg[1]);

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ie == '0 && rx_mode[0] != 2'b01 && rx_mode[0] != 2'b10 &&
        rx_mode[1] != 2'b01 && rx_mode[1] != 2'b10 && (brk_ie & brk_stat) == '0
        |=> !irq);

    p_vec_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_reg inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C,
                        8'h10, 8'h20, 8'h30, 8'h60});

    p_ext_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_ie[1] && brk_stat[1] |=> pend_reg[0]);

    p_top_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_reg[7:6] == 2'b00);
endmodule

bind irq_vector_ctl ivc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_ie(tx_ie), .rx_mode(rx_mode),
    .brk_ie(brk_ie), .brk_stat(brk_stat), .rx_byte(rx_byte), .tx_wr(tx_wr),
    .rd_data(rd_data), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .irq(irq), .pend_reg(pend_reg), .vec_reg(vec_reg)
);

// File: tb/test_irq_vector_ctl.sv
`timescale 1ns/1ps
module test_irq_vector_ctl;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            status_hi = 1'b0;
    logic [1:0]      tx_ie = 2'b11;
    logic [1:0][1:0] rx_mode = {2'b01, 2'b01};
    logic [1:0]      brk_ie = 2'b00, brk_stat = 2'b00;
    logic [1:0]      rx_byte = '0, tx_wr = '0, rd_data = '0, cmd_strobe = '0;
    logic [1:0][2:0] cmd_code = '0;
    logic            irq;
    logic [7:0]      pend_reg, vec_reg;
    int              n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    irq_vector_ctl i_irq_vector_ctl (
        .clk(clk), .rst_n(rst_n), .status_hi(status_hi), .tx_ie(tx_ie),
        .rx_mode(rx_mode), .brk_ie(brk_ie), .brk_stat(brk_stat),
        .rx_byte(rx_byte), .tx_wr(tx_wr), .rd_data(rd_data),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
        .irq(irq), .pend_reg(pend_reg), .vec_reg(vec_reg)
    );

    // ops: 0 rx byte, 1 data read, 2 tx write, 3 cmd 101, 4 cmd 111, 5 cmd 001
    // fields {ch, op[2:0], hi, pend[7:0], vec[7:0], irq}
    localparam int NV = 15;
    localparam logic [21:0] VECS [NV] = '{
        {1'b0, 3'd0, 1'b0, 8'h20, 8'h0C, 1'b1},
        {1'b0, 3'd2, 1'b0, 8'h20, 8'h0C, 1'b1},
        {1'b0, 3'd4, 1'b0, 8'h30, 8'h08, 1'b1},
        {1'b0, 3'd1, 1'b0, 8'h10, 8'h08, 1'b1},
        {1'b0, 3'd3, 1'b0, 8'h00, 8'h06, 1'b0},
        {1'b1, 3'd0, 1'b1, 8'h04, 8'h20, 1'b1},
        {1'b1, 3'd2, 1'b1, 8'h04, 8'h20, 1'b1},
        {1'b1, 3'd1, 1'b1, 8'h02, 8'h00, 1'b1},
        {1'b1, 3'd5, 1'b1, 8'h02, 8'h00, 1'b1},
        {1'b1, 3'd4, 1'b1, 8'h02, 8'h00, 1'b1},
        {1'b0, 3'd2, 1'b1, 8'h12, 8'h10, 1'b1},
        {1'b1, 3'd3, 1'b1, 8'h10, 8'h60, 1'b1},
        {1'b0, 3'd0, 1'b1, 8'h30, 8'h30, 1'b1},
        {1'b0, 3'd3, 1'b1, 8'h20, 8'h30, 1'b1},
        {1'b0, 3'd1, 1'b0, 8'h00, 8'h06, 1'b0}
    };

    function automatic string op_req(int op);
        case (op)
            0: return "R3";
            1: return "R6";
            2: return "R5";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic set_op(int ch, int op);
        case (op)
            0: rx_byte[ch] = 1'b1;
            1: rd_data[ch] = 1'b1;
            2: tx_wr[ch]   = 1'b1;
            3: begin cmd_strobe[ch] = 1'b1; cmd_code[ch] = 3'b101; end
            4: begin cmd_strobe[ch] = 1'b1; cmd_code[ch] = 3'b111; end
            5: begin cmd_strobe[ch] = 1'b1; cmd_code[ch] = 3'b001; end
            default: ;
        endcase
    endtask

    task automatic clear_ev();
        rx_byte = '0; tx_wr = '0; rd_data = '0; cmd_strobe = '0; cmd_code = '0;
    endtask

    // strobe for one cycle, sample after the registered irq has caught up
    task automatic apply(int ch, int op, logic hi);
        @(negedge clk);
        status_hi = hi;
        set_op(ch, op);
        @(negedge clk);
        clear_ev();
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_ev();
        tx_ie = 2'b11; rx_mode = {2'b01, 2'b01}; brk_ie = '0; brk_stat = '0;
        status_hi = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 pend", pend_reg, 8'h00);
        check("R10 vec", vec_reg, 8'h00);
        check("R10 irq", {7'd0, irq}, 8'h00);

        // table walk: R3 R4 R5 R6 R7 R8 and R1
        for (int i = 0; i < NV; i++) begin
            logic [21:0] v = VECS[i];
            apply(int'(v[21]), int'(v[20:18]), v[17]);
            check({op_req(int'(v[20:18])), " pend"}, pend_reg, v[16:9]);
            check("R4 vec", vec_reg, v[8:1]);
            check("R1 irq", {7'd0, irq}, {7'd0, v[0]});
        end

        // R1: irq lags the register update by one cycle
        do_reset();
        rx_byte[0] = 1'b1;
        @(negedge clk);
        rx_byte[0] = 1'b0;
        check("R1 pend immediate", pend_reg, 8'h20);
        check("R1 irq not yet", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R1 irq next cycle", {7'd0, irq}, 8'h01);

        // R2: receive modes 00 and 11 do not request
        do_reset();
        rx_mode[0] = 2'b00;
        apply(0, 0, 1'b0);
        check("R2 pend", pend_reg, 8'h20);
        check("R2 irq mode00", {7'd0, irq}, 8'h00);
        rx_mode[0] = 2'b11;
        settle();
        check("R2 irq mode11", {7'd0, irq}, 8'h00);
        rx_mode[0] = 2'b10;
        settle();
        check("R2 irq mode10", {7'd0, irq}, 8'h01);

        // R5: transmit enable off posts vector but no pending bit
        do_reset();
        tx_ie[0] = 1'b0;
        apply(0, 2, 1'b0);
        check("R5 pend tie0", pend_reg, 8'h00);
        check("R5 vec tie0", vec_reg, 8'h08);
        check("R5 irq tie0", {7'd0, irq}, 8'h00);
        tx_ie[0] = 1'b1;
        settle();
        check("R1 irq after enable", {7'd0, irq}, 8'h01);
        check("R5 pend unchanged", pend_reg, 8'h00);

        // R9: break bits
        do_reset();
        brk_ie[1] = 1'b1; brk_stat[1] = 1'b1;
        settle();
        check("R9 ext B", pend_reg, 8'h01);
        check("R9 irq B", {7'd0, irq}, 8'h01);
        brk_stat[1] = 1'b0;
        settle();
        check("R9 ext B off", pend_reg, 8'h00);
        check("R9 irq off", {7'd0, irq}, 8'h00);
        brk_ie[0] = 1'b1; brk_stat[0] = 1'b1;
        settle();
        check("R9 ext A", pend_reg, 8'h08);

        // R11: same-cycle ordering
        do_reset();
        @(negedge clk);
        rx_byte[0] = 1'b1; tx_wr[1] = 1'b1;
        @(negedge clk);
        clear_ev();
        @(negedge clk);
        check("R11 pend A rx + B tx", pend_reg, 8'h22);
        check("R11 vec B last", vec_reg, 8'h00);
        do_reset();
        @(negedge clk);
        rx_byte[0] = 1'b1; tx_wr[0] = 1'b1;
        @(negedge clk);
        clear_ev();
        @(negedge clk);
        check("R11 pend rx before tx", pend_reg, 8'h20);
        check("R11 vec rx before tx", vec_reg, 8'h0C);
        apply(0, 4, 1'b0);
        check("R8 pend release", pend_reg, 8'h30);
        check("R8 vec release", vec_reg, 8'h08);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule